// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz tick strobe into a periodic interrupt. A 4-bit rate code chooses a period that is a power of two in ticks, and a separate enable bit gates generation. A free-running tick counter serves as the phase reference. Every event therefore lands on a period-aligned count boundary. It does not land a fixed delay after the moment the code or enable changed.

The block reports each event with a one-cycle set strobe, which the register interface uses to set the periodic and interrupt-request status bits. It also drives an interrupt request that stays high until the register interface reports a read of the status register. The rate code and enable are sampled on every tick, so a new setting takes effect from the next tick onward.

Top module: `pint_gen`

## Requirements
- R1: After synchronous reset, `pflag_set` and `irq` are low and the tick counter is zero. The first event with rate code N is produced on tick number 2^(N-1) after reset.
- R2: A rate code of 0 produces no events, whether or not `per_en` is set.
- R3: While `per_en` is low, no events are produced. The tick counter keeps running during that time.
- R4: For a nonzero rate code N, events occur on exactly those ticks where the tick count since reset, modulo 2^15, is a multiple of 2^(N-1).
- R5: Rate code 1 produces an event on every tick.
- R6: `pflag_set` is high for exactly the one cycle after the clock edge at which an event tick was sampled, and at no other time.
- R7: `irq` rises in the same cycle as `pflag_set` and stays high while no status read is reported.
- R8: A `stat_rd` pulse clears `irq` at the next edge. If an event tick falls on the same edge, the event wins and `irq` stays high.
- R9: After the rate code changes, the next event falls on the first tick whose count is a multiple of the new period. Ticks already counted under the old code are not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle 32.768 kHz timebase strobe |
| rate_code | input | RATE_W | Period select; 0 disables, N gives 2^(N-1) ticks |
| per_en | input | 1 | Periodic interrupt enable |
| stat_rd | input | 1 | Status register read reported by the register interface |
| pflag_set | output | 1 | One-cycle strobe that sets the periodic status flags |
| irq | output | 1 | Interrupt request, held until a status read |

## Verification
Two things can meet in one cycle here: a new periodic event and a status read that would clear the interrupt. The bench provokes the collision by raising `stat_rd` on the same edge as a tick it has computed to be period-aligned. It expects `irq` to remain high with `pflag_set` pulsing. It then repeats the read on a tick that is not aligned, where `irq` must drop. Both outcomes are judged against a tick-count model kept in the bench.

// File: rtl/pint_pkg.sv
package pint_pkg;
  localparam int unsigned PINT_CNT_W  = 15;
  localparam int unsigned PINT_RATE_W = 4;

  // smallest rate code whose period mask covers counter bit b
  function automatic int unsigned min_code_for_bit(input int unsigned b);
    return b + 2;
  endfunction
endpackage

// File: rtl/pint_tick_ctr.sv
module pint_tick_ctr #(
  parameter int unsigned CNT_W = pint_pkg::PINT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_nxt
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pint_rate_dec.sv
module pint_rate_dec #(
  parameter int unsigned CNT_W  = pint_pkg::PINT_CNT_W,
  parameter int unsigned RATE_W = pint_pkg::PINT_RATE_W
) (
  input  logic [RATE_W-1:0] rate_code,
  output logic [CNT_W-1:0]  align_mask,
  output logic              code_live
);
  localparam int unsigned PAD_W = 32 - RATE_W;

  logic [31:0] code_ext;
  assign code_ext  = {{PAD_W{1'b0}}, rate_code};
  assign code_live = |rate_code;

  // bit b of the mask is set when the period 2^(N-1) exceeds 2^b
  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign align_mask[b] = (code_ext >= pint_pkg::min_code_for_bit(b));
  end
endmodule

// File: rtl/pint_evt_gen.sv
module pint_evt_gen #(
  parameter int unsigned CNT_W = pint_pkg::PINT_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             per_en,
  input  logic             code_live,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] align_mask,
  output logic             hit,
  output logic             pflag_set
);
  logic aligned;

  assign aligned = ((cnt_nxt & align_mask) == '0);
  assign hit     = tick & per_en & code_live & aligned;

  always_ff @(posedge clk) begin
    if (rst) pflag_set <= 1'b0;
    else     pflag_set <= hit;
  end
endmodule

// File: rtl/pint_irq_hold.sv
module pint_irq_hold (
  input  logic clk,
  input  logic rst,
  input  logic hit,
  input  logic stat_rd,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)          irq <= 1'b0;
    else if (hit)     irq <= 1'b1;
    else if (stat_rd) irq <= 1'b0;
  end
endmodule

// File: rtl/pint_gen.sv
module pint_gen #(
  parameter int unsigned CNT_W  = pint_pkg::PINT_CNT_W,
  parameter int unsigned RATE_W = pint_pkg::PINT_RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              per_en,
  input  logic              stat_rd,
  output logic              pflag_set,
  output logic              irq
);
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] align_mask;
  logic             code_live;
  logic             hit;

  pint_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick), .cnt_nxt(cnt_nxt)
  );

  pint_rate_dec #(.CNT_W(CNT_W), .RATE_W(RATE_W)) u_dec (
    .rate_code(rate_code), .align_mask(align_mask), .code_live(code_live)
  );

  pint_evt_gen #(.CNT_W(CNT_W)) u_evt (
    .clk(clk), .rst(rst), .tick(tick), .per_en(per_en),
    .code_live(code_live), .cnt_nxt(cnt_nxt), .align_mask(align_mask),
    .hit(hit), .pflag_set(pflag_set)
  );

  pint_irq_hold u_irq (
    .clk(clk), .rst(rst), .hit(hit), .stat_rd(stat_rd), .irq(irq)
  );
endmodule

// File: rtl/pint_gen_chk.sv
module pint_gen_chk #(
  parameter int unsigned RATE_W = pint_pkg::PINT_RATE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [RATE_W-1:0] rate_code,
  input logic              per_en,
  input logic              stat_rd,
  input logic              pflag_set,
  input logic              irq
);
  // R6
  strobe_follows_tick_chk: assert property (@(posedge clk) disable iff (rst)
    pflag_set |-> $past(tick));

  // R2
  code_zero_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_code == '0) |=> !pflag_set);

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !per_en |=> !pflag_set);

  // R7
  irq_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    pflag_set |-> irq);

  // R7
  irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !stat_rd) |=> irq);

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (irq == pflag_set));

  // R7
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> pflag_set);
endmodule

bind pint_gen pint_gen_chk #(.RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
  .per_en(per_en), .stat_rd(stat_rd), .pflag_set(pflag_set), .irq(irq)
);

// File: tb/pint_gen_bench.sv
module pint_gen_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       per_en = 1'b0;
  logic       stat_rd = 1'b0;
  logic       pflag_set;
  logic       irq;

  int n_chk = 0;
  int n_fail = 0;
  int tcount = 0;
  bit irq_m = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pint_gen u_pint_gen (
    .clk(clk), .rst(rst), .tick(tick), .rate_code(rate_code),
    .per_en(per_en), .stat_rd(stat_rd), .pflag_set(pflag_set), .irq(irq)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b at tick %0d", req, act, exp, tcount);
    end
  endtask

  // one tick with optional status read; checks strobe and irq, then a gap cycle
  task automatic step(input bit rd, input string req);
    bit ev;
    @(negedge clk);
    tick = 1'b1; stat_rd = rd;
    @(negedge clk);
    tick = 1'b0; stat_rd = 1'b0;
    tcount = (tcount + 1) % 32768;
    ev = per_en && (rate_code != 0) && ((tcount % (1 << (rate_code - 1))) == 0);
    if (ev) irq_m = 1'b1; else if (rd) irq_m = 1'b0;
    check({req, " strobe"}, pflag_set, ev);
    check({req, " irq"}, irq, irq_m);
    @(negedge clk);
    check("R6 strobe gap", pflag_set, 1'b0);
  endtask

  task automatic read_only();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    irq_m = 1'b0;
    check("R8 read clears", irq, 1'b0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 strobe at reset", pflag_set, 1'b0);
    check("R1 irq at reset", irq, 1'b0);
    rst = 1'b0;
    rate_code = 4'd4; per_en = 1'b1;
    // first event exactly on tick 8 after reset
    for (int i = 0; i < 8; i++) step(1'b0, "R1");
    check("R1 first event tick 8", irq, 1'b1);
    read_only();
  endtask

  task automatic t_code_zero();
    rate_code = 4'd0; per_en = 1'b1;
    for (int i = 0; i < 20; i++) step(1'b0, "R2");
  endtask

  task automatic t_disabled();
    rate_code = 4'd2; per_en = 1'b0;
    for (int i = 0; i < 13; i++) step(1'b0, "R3");
    per_en = 1'b1;
    for (int i = 0; i < 8; i++) step(1'b0, "R3 resume");
    read_only();
  endtask

  task automatic t_rate_one();
    rate_code = 4'd1; per_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, "R5");
      check("R5 every tick", irq, 1'b1);
    end
    read_only();
  endtask

  task automatic t_rates();
    per_en = 1'b1;
    rate_code = 4'd3;
    for (int i = 0; i < 17; i++) step(1'b0, "R4 code3");
    rate_code = 4'd6;
    for (int i = 0; i < 70; i++) step(1'b0, "R4 code6");
    read_only();
  endtask

  task automatic t_retune();
    per_en = 1'b1;
    rate_code = 4'd5;
    while ((tcount % 16) != 5) step(1'b0, "R9 align");
    read_only();
    rate_code = 4'd3;
    for (int i = 0; i < 10; i++) step(1'b0, "R9 new period");
    rate_code = 4'd5;
    for (int i = 0; i < 20; i++) step(1'b0, "R9 back");
  endtask

  task automatic t_collide();
    per_en = 1'b1;
    rate_code = 4'd2;
    while ((tcount % 2) != 1) step(1'b0, "R8 setup");
    // next tick is aligned: read and event collide, event must win
    step(1'b1, "R8 collide");
    check("R8 set wins", irq, 1'b1);
    // next tick is not aligned: read clears
    step(1'b1, "R8 plain read");
    check("R8 cleared", irq, 1'b0);
    // read with no pending request leaves it low
    read_only();
    check("R8 idle read", irq, 1'b0);
  endtask

  initial begin
    t_reset();
    t_code_zero();
    t_disabled();
    t_rate_one();
    t_rates();
    t_retune();
    t_collide();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule